// File: doc/BRIEF.md
# Masked Vector GF(2^8) Affine Transform Unit

This block applies an affine map over GF(2) to every byte of a wide vector. Each 64-bit lane of the data operand is paired with a 64-bit matrix word of the same lane. For output bit i, row i of the 8x8 bit matrix is taken from matrix byte 7-i. The result bit is the parity of that row ANDed with the data byte, XORed with bit i of an 8-bit constant. The same constant is used for every byte of the vector.

A broadcast select makes every lane use matrix word 0. A per-byte write mask decides which destination bytes receive the new value. A byte whose mask bit is clear is either cleared or keeps the matching byte of a separate old-destination input. A vector-length select chooses 2, 4 or 8 active lanes. Every byte above the active length is forced to zero, whatever the mask says.

A parameter selects between a purely combinational path and a single output register. In the registered form the result appears one cycle after a valid input, together with a valid flag. The output holds while no new input arrives.

Top module: `gf_affine_simd`

## Requirements
- R1: Output bit i of every active, written byte equals XOR over k of (matrix byte[7-i] bit k AND data bit k), XOR constant bit i. Matrix byte n of lane j occupies bits [64j+8n +: 8]. Data and destination byte b of lane j occupy bits [64j+8b +: 8].
- R2: Without broadcast, every byte of data lane j uses matrix word j (bits [64j +: 64]).
- R3: With `bcast_i`=1, every lane uses matrix word 0 (bits [63:0]).
- R4: `vlen_i` encoding: 0 gives 2 active lanes (128 bits), 1 gives 4 lanes (256 bits), 2 or 3 gives 8 lanes (512 bits). All destination bits of inactive lanes are 0, regardless of the mask and merge settings.
- R5: With `mask_en_i`=1, byte b of lane j is written only when `mask_i[8j+b]` is 1. With `mask_en_i`=0, every active byte is written.
- R6: With `zero_mode_i`=1, an active byte whose mask bit is clear outputs 0.
- R7: With `zero_mode_i`=0, an active byte whose mask bit is clear outputs the same byte of `old_dst_i`.
- R8: With the identity matrix word 64'h0102040810204080 in a lane and constant 0, that lane's written bytes equal the data bytes.
- R9: With REGISTERED=1, `out_valid` and `dst_o` reflect the input accepted at the previous rising edge that had `in_valid`=1. `dst_o` holds while `in_valid` is 0. Reset clears `out_valid` and `dst_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| data_i | input | 512 | Data bytes to transform |
| mat_i | input | 512 | One 8x8 matrix word per lane |
| bias_i | input | 8 | Additive constant for all bytes |
| mask_i | input | 64 | Per-byte write enables |
| mask_en_i | input | 1 | 1 = apply mask_i, 0 = write all bytes |
| zero_mode_i | input | 1 | 1 = clear masked-off bytes, 0 = merge them |
| bcast_i | input | 1 | 1 = all lanes use matrix word 0 |
| vlen_i | input | 2 | Vector length code (see R4) |
| old_dst_i | input | 512 | Previous destination for merging |
| out_valid | output | 1 | Result valid |
| dst_o | output | 512 | Destination vector |

## Verification
The bench feeds distinct random matrices per lane. A design that swapped rows (used byte i instead of 7-i), or shared one matrix across lanes, would then mismatch the bit-serial model. Broadcast cases detect a lane that ignores the select. The 128-bit and 256-bit cases detect upper lanes that leak results or merged old data. All-zero, all-one and alternating masks, in both merge and zero modes, catch an inverted mask, a swapped merge/zero choice or a wrong mask bit index. A hold check and a latency check catch an output register that reloads on idle cycles or is off by one cycle.

// File: rtl/gf_affine_pkg.sv
package gf_affine_pkg;

    localparam int BYTE_W    = 8;
    localparam int LANE_B    = 8;
    localparam int LANE_W    = BYTE_W * LANE_B;

    typedef enum logic [1:0] {
        VL_Q2  = 2'd0,
        VL_Q4  = 2'd1,
        VL_Q8  = 2'd2,
        VL_Q8X = 2'd3
    } vlen_e;

    function automatic int active_lanes(input logic [1:0] code, input int max_lanes);
        int n;
        case (vlen_e'(code))
            VL_Q2:   n = 2;
            VL_Q4:   n = 4;
            default: n = 8;
        endcase
        if (n > max_lanes) n = max_lanes;
        return n;
    endfunction

endpackage

// File: rtl/gf_affine_byte.sv
module gf_affine_byte
    import gf_affine_pkg::*;
(
    input  logic [LANE_W-1:0] mat,
    input  logic [BYTE_W-1:0] x,
    input  logic [BYTE_W-1:0] bias,
    output logic [BYTE_W-1:0] y
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        logic [BYTE_W-1:0] row_w;
        assign row_w = mat[BYTE_W*(BYTE_W-1-i) +: BYTE_W];
        assign y[i]  = (^(row_w & x)) ^ bias[i];
    end
endmodule

// File: rtl/gf_affine_lane.sv
module gf_affine_lane
    import gf_affine_pkg::*;
(
    input  logic [LANE_W-1:0] mat,
    input  logic [LANE_W-1:0] data,
    input  logic [BYTE_W-1:0] bias,
    output logic [LANE_W-1:0] res
);
    for (genvar b = 0; b < LANE_B; b++) begin : g_byte
        gf_affine_byte u_byte (
            .mat  (mat),
            .x    (data[BYTE_W*b +: BYTE_W]),
            .bias (bias),
            .y    (res[BYTE_W*b +: BYTE_W])
        );
    end
endmodule

// File: rtl/gf_affine_mask.sv
module gf_affine_mask
    import gf_affine_pkg::*;
(
    input  logic [LANE_W-1:0] res,
    input  logic [LANE_W-1:0] old,
    input  logic [LANE_B-1:0] wen,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic              active,
    output logic [LANE_W-1:0] out
);
    always_comb begin
        for (int b = 0; b < LANE_B; b++) begin
            if (!active) begin
                out[BYTE_W*b +: BYTE_W] = '0;
            end else if (!mask_en || wen[b]) begin
                out[BYTE_W*b +: BYTE_W] = res[BYTE_W*b +: BYTE_W];
            end else if (zero_mode) begin
                out[BYTE_W*b +: BYTE_W] = '0;
            end else begin
                out[BYTE_W*b +: BYTE_W] = old[BYTE_W*b +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/gf_affine_simd.sv
module gf_affine_simd
    import gf_affine_pkg::*;
#(
    parameter int LANES      = 8,
    parameter bit REGISTERED = 1'b1,
    localparam int VEC_W     = LANES * LANE_W,
    localparam int MASK_W    = LANES * LANE_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  data_i,
    input  logic [VEC_W-1:0]  mat_i,
    input  logic [BYTE_W-1:0] bias_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              mask_en_i,
    input  logic              zero_mode_i,
    input  logic              bcast_i,
    input  logic [1:0]        vlen_i,
    input  logic [VEC_W-1:0]  old_dst_i,
    output logic              out_valid,
    output logic [VEC_W-1:0]  dst_o
);
    logic [VEC_W-1:0] raw_w;
    logic [VEC_W-1:0] fin_w;
    logic [LANES-1:0] act_w;
    int               n_act_w;

    assign n_act_w = active_lanes(vlen_i, LANES);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] msel_w;
        assign msel_w   = bcast_i ? mat_i[LANE_W-1:0] : mat_i[LANE_W*j +: LANE_W];
        assign act_w[j] = (j < n_act_w);

        gf_affine_lane u_lane (
            .mat  (msel_w),
            .data (data_i[LANE_W*j +: LANE_W]),
            .bias (bias_i),
            .res  (raw_w[LANE_W*j +: LANE_W])
        );

        gf_affine_mask u_mask (
            .res       (raw_w[LANE_W*j +: LANE_W]),
            .old       (old_dst_i[LANE_W*j +: LANE_W]),
            .wen       (mask_i[LANE_B*j +: LANE_B]),
            .mask_en   (mask_en_i),
            .zero_mode (zero_mode_i),
            .active    (act_w[j]),
            .out       (fin_w[LANE_W*j +: LANE_W])
        );
    end

    if (REGISTERED) begin : g_reg
        typedef struct packed {
            logic             valid;
            logic [VEC_W-1:0] dst;
        } out_state_t;

        out_state_t st_d;
        out_state_t st_q;

        always_comb begin
            st_d       = st_q;
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.dst = fin_w;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign out_valid = st_q.valid;
        assign dst_o     = st_q.dst;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign dst_o     = fin_w;
    end

endmodule

// File: rtl/gf_affine_chk.sv
module gf_affine_chk
    import gf_affine_pkg::*;
#(
    parameter int LANES      = 8,
    parameter bit REGISTERED = 1'b1,
    localparam int VEC_W     = LANES * LANE_W,
    localparam int MASK_W    = LANES * LANE_B
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [VEC_W-1:0]  data_i,
    input logic [MASK_W-1:0] mask_i,
    input logic              mask_en_i,
    input logic              zero_mode_i,
    input logic [1:0]        vlen_i,
    input logic [VEC_W-1:0]  old_dst_i,
    input logic              out_valid,
    input logic [VEC_W-1:0]  dst_o
);
    if (REGISTERED) begin : g_seq
        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R9
        AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid); // R9
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(dst_o)); // R9
        AST_ZERO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mask_en_i && zero_mode_i && !mask_i[0]) |=> (dst_o[7:0] == 8'h00)); // R6
        AST_MERGE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mask_en_i && !zero_mode_i && !mask_i[0])
            |=> (dst_o[7:0] == $past(old_dst_i[7:0]))); // R7
        if (LANES > 2) begin : g_up
            AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && vlen_i == 2'd0) |=> (dst_o[VEC_W-1:2*LANE_W] == '0)); // R4
        end
    end else begin : g_cmb
        AST_VALID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> out_valid); // R9
        AST_ZERO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_en_i && zero_mode_i && !mask_i[0]) |-> (dst_o[7:0] == 8'h00)); // R6
        AST_MERGE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_en_i && !zero_mode_i && !mask_i[0]) |-> (dst_o[7:0] == old_dst_i[7:0])); // R7
        if (LANES > 2) begin : g_up
            AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (vlen_i == 2'd0) |-> (dst_o[VEC_W-1:2*LANE_W] == '0)); // R4
        end
    end

    logic unused_data;
    assign unused_data = ^data_i;
endmodule

bind gf_affine_simd gf_affine_chk #(
    .LANES      (LANES),
    .REGISTERED (REGISTERED)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .data_i      (data_i),
    .mask_i      (mask_i),
    .mask_en_i   (mask_en_i),
    .zero_mode_i (zero_mode_i),
    .vlen_i      (vlen_i),
    .old_dst_i   (old_dst_i),
    .out_valid   (out_valid),
    .dst_o       (dst_o)
);

// File: tb/gf_affine_simd_bench.sv
`timescale 1ns/1ps
module gf_affine_simd_bench;

    localparam logic [63:0] IDENT_QW = 64'h0102040810204080;

    typedef struct packed {
        logic [1:0] vl;
        logic       men;
        logic       zm;
        logic       bc;
        logic [1:0] mkind;
        logic [7:0] bias;
        logic [1:0] matkind;
    } case_t;

    localparam int NCASE = 12;
    localparam case_t CASES [NCASE] = '{
        '{2'd2, 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 2'd0},
        '{2'd2, 1'b1, 1'b0, 1'b0, 2'd3, 8'h63, 2'd0},
        '{2'd2, 1'b1, 1'b1, 1'b0, 2'd3, 8'hA5, 2'd0},
        '{2'd2, 1'b1, 1'b1, 1'b1, 2'd2, 8'h1F, 2'd0},
        '{2'd1, 1'b1, 1'b0, 1'b0, 2'd3, 8'h00, 2'd0},
        '{2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 8'hFF, 2'd0},
        '{2'd3, 1'b0, 1'b0, 1'b1, 2'd3, 8'h5A, 2'd2},
        '{2'd2, 1'b1, 1'b0, 1'b0, 2'd1, 8'h00, 2'd0},
        '{2'd2, 1'b1, 1'b1, 1'b0, 2'd1, 8'h77, 2'd0},
        '{2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 8'h00, 2'd1},
        '{2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00, 2'd1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 8'h3C, 2'd0}
    };

    function automatic string case_tag(input int idx);
        case (idx)
            0, 11:  return "R1";
            1, 7:   return "R7";
            2, 8:   return "R6";
            3, 6:   return "R3";
            4, 5:   return "R4";
            9, 10:  return "R8";
            default: return "R2";
        endcase
    endfunction

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] data_i = '0;
    logic [511:0] mat_i = '0;
    logic [7:0]   bias_i = '0;
    logic [63:0]  mask_i = '0;
    logic         mask_en_i = 1'b0;
    logic         zero_mode_i = 1'b0;
    logic         bcast_i = 1'b0;
    logic [1:0]   vlen_i = '0;
    logic [511:0] old_dst_i = '0;
    logic         out_valid;
    logic [511:0] dst_o;

    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;
    logic [63:0]  seed = 64'h9E3779B97F4A7C15;

    always #2.5 clk = ~clk;

    gf_affine_simd u_gf_affine_simd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_i(data_i), .mat_i(mat_i),
        .bias_i(bias_i), .mask_i(mask_i), .mask_en_i(mask_en_i), .zero_mode_i(zero_mode_i),
        .bcast_i(bcast_i), .vlen_i(vlen_i), .old_dst_i(old_dst_i),
        .out_valid(out_valid), .dst_o(dst_o)
    );

    function automatic logic [63:0] rnd64();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int q = 0; q < 8; q++) v[64*q +: 64] = rnd64();
        return v;
    endfunction

    function automatic logic [511:0] ref_model(
        input logic [511:0] d, input logic [511:0] m, input logic [511:0] od,
        input logic [63:0] mk, input logic men, input logic zm, input logic bc,
        input logic [1:0] vl, input logic [7:0] c);
        logic [511:0] r;
        int nl;
        nl = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
        for (int j = 0; j < 8; j++) begin
            for (int b = 0; b < 8; b++) begin
                logic [63:0] q;
                logic [7:0]  x, y;
                q = bc ? m[63:0] : m[64*j +: 64];
                x = d[64*j + 8*b +: 8];
                for (int i = 0; i < 8; i++) begin
                    logic p;
                    p = 1'b0;
                    for (int k = 0; k < 8; k++) p = p ^ (q[8*(7-i) + k] & x[k]);
                    y[i] = p ^ c[i];
                end
                if (j >= nl)                 r[64*j + 8*b +: 8] = 8'h00;
                else if (!men || mk[8*j+b])  r[64*j + 8*b +: 8] = y;
                else if (zm)                 r[64*j + 8*b +: 8] = 8'h00;
                else                         r[64*j + 8*b +: 8] = od[64*j + 8*b +: 8];
            end
        end
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drives one operation at a falling edge; result is sampled at the next falling edge.
    task automatic apply_op();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_mask(input logic [1:0] kind);
        case (kind)
            2'd0: mask_i = '1;
            2'd1: mask_i = '0;
            2'd2: mask_i = 64'h5555_5555_5555_5555;
            default: mask_i = rnd64();
        endcase
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9: watchdog expired actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [511:0] exp, held;
        repeat (3) @(negedge clk);
        check_bit("R9 reset valid", out_valid, 1'b0);
        check_vec("R9 reset dst", dst_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int t = 0; t < NCASE; t++) begin
            case_t cs;
            cs = CASES[t];
            data_i = rnd512();
            old_dst_i = rnd512();
            case (cs.matkind)
                2'd1: mat_i = {8{IDENT_QW}};
                2'd2: mat_i = '1;
                default: mat_i = rnd512();
            endcase
            bias_i = cs.bias;
            set_mask(cs.mkind);
            mask_en_i = cs.men;
            zero_mode_i = cs.zm;
            bcast_i = cs.bc;
            vlen_i = cs.vl;
            exp = ref_model(data_i, mat_i, old_dst_i, mask_i, cs.men, cs.zm, cs.bc, cs.vl, cs.bias);
            apply_op();
            check_vec(case_tag(t), dst_o, exp);
            if (cs.matkind == 2'd1 && cs.mkind == 2'd0)
                check_vec("R8 identity passthrough", dst_o, data_i);
        end

        // R1: all-ones rows give parity of data; 0x07 has odd parity
        data_i = '0; data_i[7:0] = 8'h07; mat_i = '1; bias_i = 8'h0F;
        mask_en_i = 1'b0; bcast_i = 1'b0; vlen_i = 2'd2;
        apply_op();
        check_vec("R1 known byte", {504'd0, dst_o[7:0]}, {504'd0, 8'hF0});

        // R2: only matrix word 1 is identity, constant zero
        data_i = rnd512(); mat_i = '0; mat_i[127:64] = IDENT_QW; bias_i = 8'h00;
        apply_op();
        check_vec("R2 per-lane matrix", dst_o, {384'd0, data_i[127:64], 64'd0});

        // R3: broadcast of identity word 0
        mat_i = rnd512(); mat_i[63:0] = IDENT_QW; bcast_i = 1'b1;
        apply_op();
        check_vec("R3 broadcast identity", dst_o, data_i);
        bcast_i = 1'b0;

        // R5: mask disabled ignores an all-zero mask
        mat_i = rnd512(); mask_i = '0; mask_en_i = 1'b0; zero_mode_i = 1'b1; bias_i = 8'h96;
        exp = ref_model(data_i, mat_i, old_dst_i, '1, 1'b1, 1'b1, 1'b0, 2'd2, 8'h96);
        apply_op();
        check_vec("R5 mask disabled", dst_o, exp);

        // R4: merge mode cannot leak old data above 256 bits
        mask_en_i = 1'b1; zero_mode_i = 1'b0; mask_i = '0; vlen_i = 2'd1;
        apply_op();
        check_vec("R4 upper cleared in merge", dst_o, {256'd0, old_dst_i[255:0]});

        // R9: output holds while idle, valid drops
        held = dst_o;
        data_i = rnd512(); old_dst_i = rnd512();
        @(negedge clk);
        check_vec("R9 hold", dst_o, held);
        check_bit("R9 valid idle", out_valid, 1'b0);
        in_valid = 1'b1;
        @(negedge clk);
        check_bit("R9 valid after accept", out_valid, 1'b1);
        in_valid = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule